// File: doc/BRIEF.md
# Current Sense Sample Window Timer

This block times the sample-and-hold window for on-resistance current sensing on one channel of a power stage. It watches the channel's low-side gate command and the PWM input, both synchronous to a reference clock of known period. When the low-side gate command falls, a blanking interval runs. After blanking the sample window opens. It closes after a fixed maximum duration, or earlier at the next PWM rising edge.

Every time the window closes, the block emits a one-cycle valid strobe. It also latches three results: the number of cycles the window was open, a flag that marks the window as too short for good current balance, and the current-gain divisor that was selected when the window opened.

A PWM rising edge during blanking cancels the sample for that cycle and raises a separate no-sample flag. All durations are given in nanoseconds and converted to clock cycles from the clock period parameter. At the defaults (8000 ps clock, 200 ns blanking, 400 ns maximum window, 200 ns minimum good window), these are 25, 50 and 25 cycles.

Top module: `cs_window_timer`

## Requirements
- R1: The edge on which the low-side gate command is first sampled low (it was high on the previous edge) starts blanking. The window output `win_o` rises on the 25th clock edge after that edge (BLANK_CYC).
- R2: Without a PWM rising edge, the window stays open for exactly 50 cycles (SAMPLE_CYC) and then closes.
- R3: A PWM rising edge (PWM high on this edge, low on the previous one) seen while the window is open closes the window on that edge. The latched length equals the number of cycles `win_o` was high, so it is 1 when the edge comes on the first open cycle.
- R4: `sample_valid_o` is high for exactly one cycle, in the cycle right after the closing edge. This is also the first cycle with `win_o` low. The length `win_len_o` is updated at the same time and then held until the next close.
- R5: `short_o` is latched at each close. It is 1 when the length is below 25 cycles (MIN_CYC) and 0 otherwise. A length of exactly 25 is not short.
- R6: A PWM rising edge during blanking cancels the window. This includes the edge on which the window would have opened. In that case no window and no valid strobe occur, `nosample_o` goes to 1, and `win_len_o`, `short_o` and `gain_div_o` keep their values. `nosample_o` returns to 0 at the next close.
- R7: `gain_sel_i` is sampled on the edge where the window opens and is reported on `gain_div_o` from the close onward. The encoding is 2'b00 = divisor 1, 2'b01 = divisor 2, 2'b10 = divisor 5, and 2'b11 = divisor 1.
- R8: Changes on the low-side gate command during blanking or an open window do not restart or extend the window. A PWM rising edge while the block is idle has no effect.
- R9: Asynchronous reset closes the window, clears `win_len_o`, `short_o`, `nosample_o` and `sample_valid_o`, and sets `gain_div_o` to 1. A low-side gate level that is already low when reset is released does not start a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lgate_i | input | 1 | Low-side gate command, high = on |
| pwm_i | input | 1 | PWM input from the controller |
| gain_sel_i | input | 2 | Current gain selection code |
| win_o | output | 1 | Sample window open |
| sample_valid_o | output | 1 | One-cycle strobe after the window closes |
| win_len_o | output | CNT_W (6) | Length of the last window in cycles |
| short_o | output | 1 | Last window shorter than MIN_CYC |
| nosample_o | output | 1 | Last cycle cancelled during blanking |
| gain_div_o | output | 3 | Gain divisor captured with the last window |

## Verification
A phase state that is off by one edge moves the rise of `win_o` and the valid strobe by a cycle. It also changes `win_len_o` by one, so every stimulus row shows it at the first close. A counter that compares against the wrong limit shows up at once on the boundary rows: a PWM edge on the opening edge, lengths of 24 and 25 around the short threshold, and a PWM edge on the last open cycle. Result registers that capture at the wrong moment appear on the next close, as a wrong gain divisor after a mid-window change of selection, or as a length that changed after a cancelled cycle.

// File: rtl/cs_window_pkg.sv
`timescale 1ns/1ps
package cs_window_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BLANK  = 2'd1,
    PH_SAMPLE = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    GSEL_FULL  = 2'b00,
    GSEL_HALF  = 2'b01,
    GSEL_FIFTH = 2'b10,
    GSEL_RSVD  = 2'b11
  } gain_sel_e;

  // round up so a window is never shorter than asked
  function automatic int ns_to_cycles(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/cs_edge_det.sv
`timescale 1ns/1ps
module cs_edge_det #(
  parameter bit RISING  = 1'b1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate

endmodule

// File: rtl/cs_window_fsm.sv
`timescale 1ns/1ps
module cs_window_fsm
  import cs_window_pkg::*;
#(
  parameter int BLANK_CYC  = 25,
  parameter int SAMPLE_CYC = 50,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             open_o,
  output logic             enter_o,
  output logic             close_o,
  output logic             skip_o,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] BLANK_LAST  = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_MAX  = CNT_W'(SAMPLE_CYC);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q  <= PH_BLANK;
            cnt_q <= '0;
          end
        end
        PH_BLANK: begin
          // pwm edge wins over opening on the same edge
          if (stop_i) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else if (cnt_q == BLANK_LAST) begin
            ph_q  <= PH_SAMPLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SAMPLE: begin
          if (stop_i || cnt_q == SAMPLE_LAST) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  always_comb begin
    open_o  = (ph_q == PH_SAMPLE);
    enter_o = (ph_q == PH_BLANK) && !stop_i && (cnt_q == BLANK_LAST);
    close_o = (ph_q == PH_SAMPLE) && (stop_i || cnt_q == SAMPLE_LAST);
    skip_o  = (ph_q == PH_BLANK) && stop_i;
    len_o   = cnt_q + 1'b1;
  end

  // R1: the window only opens out of blanking
  a_r1_open_after_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(ph_q) == PH_BLANK);

  // R2: a closing window never reports more than the maximum
  a_r2_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> (len_o != '0) && (len_o <= SAMPLE_MAX));

  // R8: a new gate fall while open does not restart blanking
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SAMPLE) && start_i |=> ph_q != PH_BLANK);

endmodule

// File: rtl/cs_gain_dec.sv
`timescale 1ns/1ps
module cs_gain_dec
  import cs_window_pkg::*;
(
  input  logic [1:0] sel_i,
  output logic [2:0] div_o
);

  always_comb begin
    unique case (gain_sel_e'(sel_i))
      GSEL_HALF:  div_o = 3'd2;
      GSEL_FIFTH: div_o = 3'd5;
      default:    div_o = 3'd1;
    endcase
  end

endmodule

// File: rtl/cs_result_reg.sv
`timescale 1ns/1ps
module cs_result_reg #(
  parameter int MIN_CYC = 25,
  parameter int CNT_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             close_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [2:0]       div_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] len_o,
  output logic             short_o,
  output logic             nosample_o,
  output logic [2:0]       div_o
);

  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_CYC);

  logic [2:0] div_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      len_o      <= '0;
      short_o    <= 1'b0;
      nosample_o <= 1'b0;
      div_o      <= 3'd1;
      div_pend_q <= 3'd1;
    end else begin
      valid_o <= close_i;
      if (enter_i) div_pend_q <= div_i;
      if (close_i) begin
        len_o      <= len_i;
        short_o    <= (len_i < MIN_LEN);
        nosample_o <= 1'b0;
        div_o      <= div_pend_q;
      end else if (skip_i) begin
        nosample_o <= 1'b1;
      end
    end
  end

  // R4: strobe is a single cycle
  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6: a cancelled cycle leaves the held results alone
  a_r6_skip_keeps_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nosample_o) |-> !valid_o && $stable(len_o) && $stable(short_o) && $stable(div_o));

endmodule

// File: rtl/cs_window_timer.sv
`timescale 1ns/1ps
module cs_window_timer
  import cs_window_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int BLANK_NS      = 200,
  parameter int SAMPLE_NS     = 400,
  parameter int MIN_NS        = 200,
  localparam int BLANK_CYC    = ns_to_cycles(BLANK_NS, CLK_PERIOD_PS),
  localparam int SAMPLE_CYC   = ns_to_cycles(SAMPLE_NS, CLK_PERIOD_PS),
  localparam int MIN_CYC      = ns_to_cycles(MIN_NS, CLK_PERIOD_PS),
  localparam int MAX_CYC      = (BLANK_CYC > SAMPLE_CYC)
                                ? ((BLANK_CYC > MIN_CYC) ? BLANK_CYC : MIN_CYC)
                                : ((SAMPLE_CYC > MIN_CYC) ? SAMPLE_CYC : MIN_CYC),
  localparam int CNT_W        = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lgate_i,
  input  logic             pwm_i,
  input  logic [1:0]       gain_sel_i,
  output logic             win_o,
  output logic             sample_valid_o,
  output logic [CNT_W-1:0] win_len_o,
  output logic             short_o,
  output logic             nosample_o,
  output logic [2:0]       gain_div_o
);

  logic             lg_fall, pwm_rise;
  logic             enter, close, skip;
  logic [CNT_W-1:0] len;
  logic [2:0]       div;

  cs_edge_det #(.RISING(1'b0), .RST_VAL(1'b0)) u_lg_edge (
    .clk_i, .rst_ni, .sig_i(lgate_i), .edge_o(lg_fall)
  );

  // reset high: a pwm already high at release is not an edge
  cs_edge_det #(.RISING(1'b1), .RST_VAL(1'b1)) u_pwm_edge (
    .clk_i, .rst_ni, .sig_i(pwm_i), .edge_o(pwm_rise)
  );

  cs_window_fsm #(
    .BLANK_CYC(BLANK_CYC), .SAMPLE_CYC(SAMPLE_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .start_i(lg_fall), .stop_i(pwm_rise),
    .open_o(win_o), .enter_o(enter), .close_o(close), .skip_o(skip),
    .len_o(len)
  );

  cs_gain_dec u_gain (.sel_i(gain_sel_i), .div_o(div));

  cs_result_reg #(.MIN_CYC(MIN_CYC), .CNT_W(CNT_W)) u_res (
    .clk_i, .rst_ni,
    .enter_i(enter), .close_i(close), .skip_i(skip),
    .len_i(len), .div_i(div),
    .valid_o(sample_valid_o), .len_o(win_len_o), .short_o(short_o),
    .nosample_o(nosample_o), .div_o(gain_div_o)
  );

  // R4: strobe marks the first cycle after an open window
  a_r4_valid_at_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> !win_o && $past(win_o));

  // R6: a cancelled cycle never shows an open window
  a_r6_no_open_on_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nosample_o) |-> !win_o);

  // R9: nothing is reported while in reset
  a_r9_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !win_o && !sample_valid_o && !nosample_o);

endmodule

// File: tb/cs_window_timer_test.sv
`timescale 1ns/1ps
module cs_window_timer_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lgate = 1'b1;
  logic       pwm = 1'b0;
  logic [1:0] gain_sel = 2'b00;
  logic       win_o, sample_valid_o, short_o, nosample_o;
  logic [5:0] win_len_o;
  logic [2:0] gain_div_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cs_window_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .lgate_i(lgate), .pwm_i(pwm),
    .gain_sel_i(gain_sel), .win_o(win_o), .sample_valid_o(sample_valid_o),
    .win_len_o(win_len_o), .short_o(short_o), .nosample_o(nosample_o),
    .gain_div_o(gain_div_o)
  );

  // x: pwm edge index (0 = none); len 0 marks a cancelled cycle
  localparam int NV = 10;
  localparam int V_X[NV]     = '{0,  75, 74, 50, 49, 26, 25, 60, 1, 40};
  localparam int V_GSEL[NV]  = '{0,  1,  2,  3,  0,  1,  2,  2,  0, 1};
  localparam int V_LEN[NV]   = '{50, 50, 49, 25, 24, 1,  0,  35, 0, 15};
  localparam int V_SHORT[NV] = '{0,  0,  0,  0,  1,  1,  0,  0,  0, 1};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int div_of(input int g);
    return (g == 1) ? 2 : (g == 2) ? 5 : 1;
  endfunction

  // drops the gate before edge E0; k-th observation follows edge E(k-1)
  task automatic run_window(input int x, input int gsel, input bit glitch,
                            input int gk, input int gnew,
                            output int wins, output int vals, output int vidx,
                            output int first_open);
    gain_sel = 2'(gsel);
    wins = 0; vals = 0; vidx = -1; first_open = -1;
    @(negedge clk);
    lgate = 1'b0;
    for (int k = 1; k <= 90; k++) begin
      @(negedge clk);
      if (win_o) begin
        wins++;
        if (first_open < 0) first_open = k - 1;
      end
      if (sample_valid_o) begin
        vals++;
        vidx = k - 1;
      end
      if (k == x) pwm = 1'b1;
      if (k == gk) gain_sel = 2'(gnew);
      if (glitch && k == 40) lgate = 1'b1;
      if (glitch && k == 42) lgate = 1'b0;
    end
    pwm = 1'b0;
    lgate = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int wins, vals, vidx, fo;
    int p_len, p_short, p_div;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "win", int'(win_o), 0);
    chk("R9", "len", int'(win_len_o), 0);
    chk("R9", "gain", int'(gain_div_o), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "valid", int'(sample_valid_o), 0);
    chk("R9", "nosample", int'(nosample_o), 0);
    chk("R9", "short", int'(short_o), 0);

    p_len = 0; p_short = 0; p_div = 1;
    for (int i = 0; i < NV; i++) begin
      run_window(V_X[i], V_GSEL[i], 1'b0, 0, 0, wins, vals, vidx, fo);
      if (V_LEN[i] == 0) begin
        chk("R6", "valid count", vals, 0);
        chk("R6", "open cycles", wins, 0);
        chk("R6", "nosample", int'(nosample_o), 1);
        chk("R6", "held len", int'(win_len_o), p_len);
        chk("R6", "held short", int'(short_o), p_short);
        chk("R6", "held gain", int'(gain_div_o), p_div);
      end else begin
        chk("R1", "open edge", fo, 25);
        chk((V_X[i] == 0) ? "R2" : "R3", "close edge", vidx, (V_X[i] == 0) ? 75 : V_X[i]);
        chk("R4", "valid count", vals, 1);
        chk("R3", "open cycles", wins, V_LEN[i]);
        chk("R4", "len", int'(win_len_o), V_LEN[i]);
        chk("R5", "short", int'(short_o), V_SHORT[i]);
        chk("R6", "nosample cleared", int'(nosample_o), 0);
        chk("R7", "gain", int'(gain_div_o), div_of(V_GSEL[i]));
        p_len = V_LEN[i]; p_short = V_SHORT[i]; p_div = div_of(V_GSEL[i]);
      end
    end

    // R8: gate toggles inside the window do not restart it
    run_window(0, 0, 1'b1, 0, 0, wins, vals, vidx, fo);
    chk("R8", "glitch close edge", vidx, 75);
    chk("R8", "glitch len", int'(win_len_o), 50);
    chk("R8", "glitch valid count", vals, 1);

    // R8: pwm rise while idle does nothing
    pwm = 1'b1;
    vals = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (sample_valid_o || win_o) vals++;
    end
    pwm = 1'b0;
    chk("R8", "idle pwm activity", vals, 0);
    chk("R8", "idle pwm nosample", int'(nosample_o), 0);
    chk("R8", "idle pwm len", int'(win_len_o), 50);

    // R7: selection captured at open, later changes ignored
    run_window(0, 2, 1'b0, 30, 1, wins, vals, vidx, fo);
    chk("R7", "gain after open change", int'(gain_div_o), 5);
    run_window(0, 2, 1'b0, 10, 0, wins, vals, vidx, fo);
    chk("R7", "gain before open change", int'(gain_div_o), 1);

    // R9: reset in the middle of a window
    @(negedge clk);
    lgate = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9", "mid win open", int'(win_o), 1);
    rst_ni = 1'b0;
    #1;
    chk("R9", "mid win closed", int'(win_o), 0);
    chk("R9", "mid len", int'(win_len_o), 0);
    chk("R9", "mid gain", int'(gain_div_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    vals = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (sample_valid_o || win_o) vals++;
    end
    chk("R9", "no window from low gate at release", vals, 0);
    lgate = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule